// File: doc/BRIEF.md
# MMU Fault Status Capture Register

This block records what went wrong when a memory access faults, so that the fault handler can read it later. Each fault event arrives as a single-cycle pulse. The pulse carries the following details:

- an encoded fault kind;
- three access-descriptor bits (supervisor, instruction fetch, store);
- the translation-table level at which the fault was found;
- bus-error, timeout and uncorrectable-data flags;
- a faulting address, with a flag saying whether that address is meaningful.

The block packs these details into one status word and keeps the address in a companion register. Both can be read through a small register port that has a read strobe and a one-bit select.

Each new fault replaces the kind, access, level and address-valid fields. The three error flags instead gather up by OR until the status word is read. If a fault lands while an earlier captured fault is still unread, a sticky overwrite flag is set. Reading the status word returns its value and clears it. Reading the address has no side effect.

An interrupt-pending output is high while the status word holds a nonzero fault kind or any error flag.

Top module: `fault_status_capture`

## Requirements
- R1: After synchronous reset the status word, the address register, `rd_data` and `irq_pending` are all zero.
- R2: On a fault event, status bits [4:2] take the incoming fault code: 0 none, 1 invalid address, 2 protection, 3 privilege, 4 translation, 5 bus error on access, 6 internal, 7 reserved.
- R3: On a fault event, status bit 5 takes the supervisor flag, bit 6 the instruction-fetch flag and bit 7 the store flag.
- R4: On a fault event, status bits [9:8] take the table level: 0 context, 1 region, 2 segment, 3 page.
- R5: Status bit 1 takes the incoming address-valid flag of the newest fault. The address register loads only when that flag is set; otherwise it keeps its old value.
- R6: Status bit 10 (bus error), bit 11 (timeout) and bit 12 (uncorrectable) OR-accumulate over faults until a status read. The fields in R2 to R4 are replaced by the newest fault.
- R7: Status bit 0 is set when a fault arrives while a previously captured fault has not been read. It stays set until a status read.
- R8: A read with `reg_sel`=0 presents the status word on `rd_data` one cycle later and clears the status word.
- R9: When a fault and a status read occur in the same cycle, the read returns the old word. The new fault is then captured into a cleared word: bit 0 stays 0 and no old error flags are merged in.
- R10: A read with `reg_sel`=1 presents the address on `rd_data` one cycle later and changes no state.
- R11: `irq_pending` equals (bits [4:2] nonzero or any of bits [12:10] set) of the status word, and it updates on the same edge as the word.
- R12: `rd_data` holds its value in cycles without a read. Status bits above bit 12 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | Fault event strobe |
| flt_kind | input | 3 | Encoded fault kind |
| flt_super | input | 1 | Access was supervisor |
| flt_fetch | input | 1 | Access was an instruction fetch |
| flt_store | input | 1 | Access was a store |
| flt_level | input | 2 | Table level at fault |
| flt_bus_err | input | 1 | Bus error flag |
| flt_timeout | input | 1 | Bus timeout flag |
| flt_uncorr | input | 1 | Uncorrectable data flag |
| flt_addr_ok | input | 1 | Faulting address is valid |
| flt_addr | input | AW | Faulting address |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects address |
| rd_data | output | DW | Registered read data |
| irq_pending | output | 1 | Fault awaiting service |

## Verification
The bench targets four corner cases:

- **Same-cycle fault and status read.** A design that gets this wrong either loses the new fault or sets the overwrite flag and merges stale error bits.
- **A fault of kind "none" with no error flags.** It must still count as a captured fault for the overwrite flag, yet it must leave the interrupt low. A design keyed on nonzero contents would miss the overwrite.
- **A fault without a valid address.** A faulty design would clobber the stored address.
- **Two faults with different error flags.** A faulty design would keep only the newest flags.

Address reads between faults must leave the status word and the interrupt untouched.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int STAT_W = 13;

  // Status word layout, MSB first: bit 12 down to bit 0
  typedef struct packed {
    logic       uncorr;   // 12
    logic       tmo;      // 11
    logic       berr;     // 10
    logic [1:0] lvl;      // 9:8
    logic       store;    // 7
    logic       fetch;    // 6
    logic       sup;      // 5
    logic [2:0] kind;     // 4:2
    logic       fav;      // 1
    logic       ovw;      // 0
  } stat_t;

  typedef struct packed {
    logic [2:0] kind;
    logic       sup;
    logic       fetch;
    logic       store;
    logic [1:0] lvl;
    logic       berr;
    logic       tmo;
    logic       uncorr;
    logic       aok;
  } evt_t;
endpackage

// File: rtl/fsc_capture.sv
module fsc_capture
  import fsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  evt_valid,
  input  evt_t  evt,
  input  logic  clr,
  output stat_t stat_q,
  output logic  irq_q
);
  stat_t base, nxt;
  logic  held_q, held_base;

  always_comb begin
    base      = clr ? '0 : stat_q;
    held_base = clr ? 1'b0 : held_q;
    nxt       = base;
    if (evt_valid) begin
      nxt.kind   = evt.kind;
      nxt.sup    = evt.sup;
      nxt.fetch  = evt.fetch;
      nxt.store  = evt.store;
      nxt.lvl    = evt.lvl;
      nxt.fav    = evt.aok;
      nxt.berr   = base.berr   | evt.berr;
      nxt.tmo    = base.tmo    | evt.tmo;
      nxt.uncorr = base.uncorr | evt.uncorr;
      nxt.ovw    = base.ovw    | held_base;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      held_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= nxt;
      held_q <= held_base | evt_valid;
      irq_q  <= (nxt.kind != 3'd0) | nxt.berr | nxt.tmo | nxt.uncorr;
    end
  end
endmodule

// File: rtl/fsc_addr_reg.sv
module fsc_addr_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= addr_in;
  end
endmodule

// File: rtl/fsc_readout.sv
module fsc_readout
  import fsc_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic          sel,
  input  stat_t         stat,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rd_data
);
  localparam int PADW = DW - STAT_W;

  logic [DW-1:0] stat_ext;
  logic [DW-1:0] addr_ext;

  assign stat_ext = {{PADW{1'b0}}, stat};

  generate
    if (AW >= DW) begin : g_trunc
      assign addr_ext = addr[DW-1:0];
    end else begin : g_pad
      assign addr_ext = {{(DW-AW){1'b0}}, addr};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)     rd_data <= '0;
    else if (rd) rd_data <= sel ? addr_ext : stat_ext;
  end
endmodule

// File: rtl/fault_status_capture.sv
module fault_status_capture
  import fsc_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flt_valid,
  input  logic [2:0]    flt_kind,
  input  logic          flt_super,
  input  logic          flt_fetch,
  input  logic          flt_store,
  input  logic [1:0]    flt_level,
  input  logic          flt_bus_err,
  input  logic          flt_timeout,
  input  logic          flt_uncorr,
  input  logic          flt_addr_ok,
  input  logic [AW-1:0] flt_addr,
  input  logic          reg_rd,
  input  logic          reg_sel,
  output logic [DW-1:0] rd_data,
  output logic          irq_pending
);
  evt_t              evt;
  stat_t             stat_q;
  logic [STAT_W-1:0] stat_bits;
  logic [AW-1:0]     addr_q;
  logic              stat_clr;

  assign evt = '{kind: flt_kind, sup: flt_super, fetch: flt_fetch,
                 store: flt_store, lvl: flt_level, berr: flt_bus_err,
                 tmo: flt_timeout, uncorr: flt_uncorr, aok: flt_addr_ok};

  assign stat_clr  = reg_rd & ~reg_sel;
  assign stat_bits = stat_q;

  fsc_capture u_cap (
    .clk(clk), .rst(rst), .evt_valid(flt_valid), .evt(evt),
    .clr(stat_clr), .stat_q(stat_q), .irq_q(irq_pending)
  );

  fsc_addr_reg #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .load(flt_valid & flt_addr_ok),
    .addr_in(flt_addr), .addr_q(addr_q)
  );

  fsc_readout #(.DW(DW), .AW(AW)) u_rd (
    .clk(clk), .rst(rst), .rd(reg_rd), .sel(reg_sel),
    .stat(stat_q), .addr(addr_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          flt_valid,
  input logic          reg_rd,
  input logic          reg_sel,
  input logic [DW-1:0] rd_data,
  input logic          irq_pending,
  input logic [12:0]   stat
);
  // R8
  stat_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_sel && !flt_valid) |=> (stat == 13'd0));

  // R10
  addr_read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_sel && !flt_valid) |=> $stable(stat));

  // R12
  rd_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(rd_data));

  // R12
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_sel) |=> (rd_data[DW-1:13] == '0));

  // R11
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pending == ((stat[4:2] != 3'd0) || (stat[12:10] != 3'd0)));

  // R7
  ovw_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (stat[0] && !(reg_rd && !reg_sel)) |=> stat[0]);

  // R9
  same_cycle_no_ovw_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && reg_rd && !reg_sel) |=> !stat[0]);

  // R6
  berr_accum_chk: assert property (@(posedge clk) disable iff (rst)
    (stat[10] && !(reg_rd && !reg_sel)) |=> stat[10]);
endmodule

bind fault_status_capture fsc_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .flt_valid(flt_valid), .reg_rd(reg_rd),
  .reg_sel(reg_sel), .rd_data(rd_data), .irq_pending(irq_pending),
  .stat(stat_bits)
);

// File: tb/test_fault_status_capture.sv
module test_fault_status_capture;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flt_valid = 0, flt_super = 0, flt_fetch = 0, flt_store = 0;
  logic [2:0]    flt_kind = 0;
  logic [1:0]    flt_level = 0;
  logic          flt_bus_err = 0, flt_timeout = 0, flt_uncorr = 0, flt_addr_ok = 0;
  logic [AW-1:0] flt_addr = 0;
  logic          reg_rd = 0, reg_sel = 0;
  logic [DW-1:0] rd_data;
  logic          irq_pending;

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural reference state
  longint m_stat = 0, m_addr = 0, m_rd = 0;
  bit     m_held = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_status_capture #(.DW(DW), .AW(AW)) i_fault_status_capture (.*);

  always @(posedge clk) begin
    longint base, nw;
    bit     hb, is_stat;
    if (rst) begin
      m_stat = 0; m_addr = 0; m_rd = 0; m_held = 0; m_irq = 0;
    end else begin
      is_stat = reg_rd && !reg_sel;
      if (reg_rd) m_rd = reg_sel ? m_addr : m_stat;
      base = is_stat ? 0 : m_stat;
      hb   = is_stat ? 0 : m_held;
      if (flt_valid) begin
        nw = (longint'(flt_kind) << 2) | (longint'(flt_super) << 5)
           | (longint'(flt_fetch) << 6) | (longint'(flt_store) << 7)
           | (longint'(flt_level) << 8) | (longint'(flt_addr_ok) << 1)
           | (base & 'h1C00) | (longint'(flt_bus_err) << 10)
           | (longint'(flt_timeout) << 11) | (longint'(flt_uncorr) << 12)
           | (base & 1) | longint'(hb);
        m_stat = nw;
        m_held = 1;
        if (flt_addr_ok) m_addr = flt_addr;
      end else begin
        m_stat = base;
        m_held = hb;
      end
      m_irq = (((m_stat >> 2) & 7) != 0) || ((m_stat & 'h1C00) != 0);
    end
  end

  task automatic check(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    check("model rd_data", longint'(rd_data), m_rd);
    check("model irq", longint'(irq_pending), longint'(m_irq));
  endtask

  task automatic set_fault(input int kind, input bit sup, input bit fet, input bit sto,
                           input int lvl, input bit be, input bit to, input bit uc,
                           input bit aok, input longint addr);
    flt_valid = 1; flt_kind = 3'(kind); flt_super = sup; flt_fetch = fet;
    flt_store = sto; flt_level = 2'(lvl); flt_bus_err = be; flt_timeout = to;
    flt_uncorr = uc; flt_addr_ok = aok; flt_addr = AW'(addr);
  endtask

  task automatic idle();
    flt_valid = 0; reg_rd = 0;
  endtask

  task automatic fault(input int kind, input bit sup, input bit fet, input bit sto,
                       input int lvl, input bit be, input bit to, input bit uc,
                       input bit aok, input longint addr);
    set_fault(kind, sup, fet, sto, lvl, be, to, uc, aok, addr);
    tick();
    idle();
  endtask

  task automatic rd(input bit sel);
    reg_rd = 1; reg_sel = sel;
    tick();
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    check("R1 rd_data", longint'(rd_data), 0);
    check("R1 irq", longint'(irq_pending), 0);
    rd(0); check("R1 status", longint'(rd_data), 0);
    rd(1); check("R1 addr", longint'(rd_data), 0);

    // R2 R3 R4: protection, supervisor store, page level, address valid
    fault(2, 1, 0, 1, 3, 0, 0, 0, 1, 'h1234);
    check("R11 irq after fault", longint'(irq_pending), 1);
    rd(1); check("R10 addr read", longint'(rd_data), 'h1234);
    check("R10 irq kept", longint'(irq_pending), 1);
    rd(0); check("R2 R3 R4 status word", longint'(rd_data), 'h3AA);
    check("R11 irq cleared", longint'(irq_pending), 0);
    rd(0); check("R8 cleared on read", longint'(rd_data), 0);

    // R5 R6 R7: two faults, second overwrites unread first
    fault(5, 0, 1, 0, 0, 1, 0, 0, 0, 'hDEAD);
    rd(1); check("R5 addr kept when not valid", longint'(rd_data), 'h1234);
    fault(1, 1, 0, 0, 2, 0, 1, 0, 1, 'h80);
    rd(1); check("R5 addr loaded", longint'(rd_data), 'h80);
    rd(0); check("R6 R7 accumulated word", longint'(rd_data), 'hE27);

    // R9 same-cycle fault and status read
    fault(4, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    set_fault(3, 0, 0, 1, 1, 0, 0, 1, 0, 0);
    reg_rd = 1; reg_sel = 0;
    tick(); idle();
    check("R9 old word returned", longint'(rd_data), 'h10);
    rd(0); check("R9 fresh capture", longint'(rd_data), 'h118C);

    // R7 R11: kind none faults still count as captured
    fault(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R11 no irq for empty fault", longint'(irq_pending), 0);
    fault(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R11 no irq with only overwrite", longint'(irq_pending), 0);
    rd(0); check("R7 overwrite from empty fault", longint'(rd_data), 'h1);

    // R12 hold and upper zero bits
    fault(7, 1, 1, 1, 3, 1, 1, 1, 1, 'hFFFF_FFFF);
    rd(0); check("R12 all fields", longint'(rd_data), 'h1FFE);
    repeat (3) tick();
    check("R12 rd_data holds", longint'(rd_data), 'h1FFE);
    check("R12 upper bits zero", longint'(rd_data >> 13), 0);
    rd(1); check("R10 full addr", longint'(rd_data), 'hFFFF_FFFF);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule